// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block stores the two-byte payloads that a host writes for two vertical-blanking data channels. The caption channel goes out on line 21 of the first field. The extended-data channel goes out on line 284 of the second field. When the timing generator reaches the start pixel of an assigned line and that channel is enabled, the block emits a one-bit waveform level stream and raises an activity flag for the length of the burst. Downstream shaping logic turns this stream into the analog-looking data line. The stream is a clock run-in, a three-bit start pattern and sixteen payload bits.

The host writes each byte separately. A pair becomes eligible for transmission only when its second byte is written. When a line comes around and no new pair has been committed since the previous burst on that channel, the block sends two null characters (0x80 each) instead. Parity is part of the byte written by the host and is sent unchanged. Line numbers use 525-line counting in every video standard, so 625-line operation uses the same line, field and pixel timing.

The write port is a plain single-cycle strobe with no back-pressure. Every strobe is accepted in the cycle it is presented. The level stream has no ready input: the downstream path consumes one level per pixel tick.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `cc_active` and `cc_level` are 0 and neither channel holds a committed pair, so the first burst on each channel carries 0x80, 0x80.
- R2: A write to address 1 (caption) or 3 (extended data) commits that byte, together with the byte last written to address 0 or 2 respectively, as a new pair. A write to address 0 or 2 alone commits nothing.
- R3: A burst on a channel with no pair committed since its previous burst carries the null byte 0x80 as both the first and the second byte.
- R4: A caption burst starts only when `line_num`=21, `field`=0 and `cc_enable`=1 at the tick where `pix_pos`=START_PIX. An extended-data burst starts only when `line_num`=284, `field`=1 and `xds_enable`=1 at that tick. On any other line, field or enable setting nothing is sent and the pending pair is kept.
- R5: A burst starts at the tick where `pix_pos`=START_PIX (default 130) and is 26 bit periods of 27 ticks each. In each of the first 7 periods, `cc_level` is 1 for ticks 0 to 12 and 0 for ticks 13 to 26. The next three periods carry 0, 0, 1. The last 16 periods carry the first byte and then the second byte, each least significant bit first.
- R6: `cc_active` is 1 from the start tick through the 702nd tick of the burst, and is 0 otherwise. `cc_level` is 0 whenever `cc_active` is 0.
- R7: Starting a burst clears that channel's new-pair flag. A pair committed while a burst is in progress goes out on the channel's next burst.
- R8: All eight bits of each byte are sent exactly as written, including bit 7 (the host-supplied parity). The block computes no parity.
- R9: The two channels hold separate pairs and flags. Writes to one channel never change what the other channel sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_tick | input | 1 | Pixel-rate enable; the burst advances one tick per pulse |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | 0/1: caption first/second byte; 2/3: extended-data first/second byte |
| wr_data | input | 8 | Byte value, parity in bit 7 |
| cc_enable | input | 1 | Enable for the caption channel |
| xds_enable | input | 1 | Enable for the extended-data channel |
| line_num | input | 10 | Current line in 525-line counting |
| field | input | 1 | 0 = first field, 1 = second field |
| pix_pos | input | 11 | Pixel position within the line |
| cc_active | output | 1 | High while a burst is being sent |
| cc_level | output | 1 | Waveform level of the burst |

## Verification
The assertions assume that the timing generator holds `line_num` and `field` steady for a whole line. They also assume that `pix_pos` reaches START_PIX once per line on a tick, and that the host presents at most one byte per clock. The stimulus follows these rules. It steps `pix_pos` through a full line with a tick on every other clock and changes the line and field only between lines. It issues one write per clock, including writes made inside a burst.

// File: rtl/ccins_pkg.sv
package ccins_pkg;
  localparam int NUM_CH = 2;
  localparam logic [7:0] NULL_CHAR = 8'h80;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } cc_pair_t;
endpackage

// File: rtl/cc_pair_store.sv
module cc_pair_store
  import ccins_pkg::*;
#(
  parameter int CH_ID = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       take,
  output cc_pair_t   send_pair,
  output logic       fresh
);
  localparam logic CH_BIT = 1'(CH_ID);

  logic     sel, lo_wr, hi_wr;
  logic [7:0] stage_lo;
  cc_pair_t held;

  assign sel   = wr_en && (wr_addr[1] == CH_BIT);
  assign lo_wr = sel && !wr_addr[0];
  assign hi_wr = sel && wr_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo <= '0;
      held     <= '0;
      fresh    <= 1'b0;
    end else begin
      if (lo_wr) stage_lo <= wr_data;
      if (hi_wr) begin
        held  <= '{hi: wr_data, lo: stage_lo};
        fresh <= 1'b1;
      end else if (take) begin
        fresh <= 1'b0;
      end
    end
  end

  assign send_pair = fresh ? held : '{hi: NULL_CHAR, lo: NULL_CHAR};

  // R2
  commit_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> fresh);
  // R7
  take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hi_wr) |=> !fresh);
  // R2
  first_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !take) |=> $stable(fresh));
endmodule

// File: rtl/cc_wave_ser.sv
module cc_wave_ser #(
  parameter int BIT_TICKS  = 27,
  parameter int RUNIN_BITS = 7,
  parameter int DATA_BITS  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] payload,
  output logic                 active,
  output logic                 level
);
  localparam int TOTAL_BITS = RUNIN_BITS + 3 + DATA_BITS;
  localparam int IDX_W = $clog2(TOTAL_BITS + 1);
  localparam int PH_W  = $clog2(BIT_TICKS + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TOTAL_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_RUNEND = IDX_W'(RUNIN_BITS);
  localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(RUNIN_BITS + 2);
  localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(RUNIN_BITS + 3);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(BIT_TICKS - 1);
  localparam logic [PH_W-1:0]  PH_HALF   = PH_W'(BIT_TICKS / 2);

  logic [IDX_W-1:0]     idx;
  logic [PH_W-1:0]      phase;
  logic [DATA_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      phase  <= '0;
      shreg  <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      phase  <= '0;
      shreg  <= payload;
    end else if (active && tick) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        if (idx >= IDX_DATA) shreg <= shreg >> 1;
        if (idx == IDX_LAST) active <= 1'b0;
        else                 idx    <= idx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  always_comb begin
    if (!active)             level = 1'b0;
    else if (idx < IDX_RUNEND) level = (phase < PH_HALF);
    else if (idx < IDX_ONE)  level = 1'b0;
    else if (idx == IDX_ONE) level = 1'b1;
    else                     level = shreg[0];
  end

  // R6
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && !start && phase == PH_LAST && idx == IDX_LAST) |=> !active);
  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !level);
  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= IDX_LAST && phase <= PH_LAST));
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
  import ccins_pkg::*;
#(
  parameter int START_PIX  = 130,
  parameter int CC_LINE    = 21,
  parameter int XDS_LINE   = 284,
  parameter int BIT_TICKS  = 27,
  parameter int RUNIN_BITS = 7,
  parameter int LINE_W     = 10,
  parameter int PIX_W      = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              cc_enable,
  input  logic              xds_enable,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic [PIX_W-1:0]  pix_pos,
  output logic              cc_active,
  output logic              cc_level
);
  localparam logic [PIX_W-1:0]  START_V = PIX_W'(START_PIX);
  localparam logic [LINE_W-1:0] CC_V    = LINE_W'(CC_LINE);
  localparam logic [LINE_W-1:0] XDS_V   = LINE_W'(XDS_LINE);

  cc_pair_t          pairs [NUM_CH];
  logic [NUM_CH-1:0] fresh_v;
  logic [NUM_CH-1:0] take;
  logic              at_start, hit_cc, hit_xds, start;
  cc_pair_t          payload;

  assign at_start = pix_tick && (pix_pos == START_V) && !cc_active;
  assign hit_cc   = at_start && cc_enable  && (line_num == CC_V)  && !field;
  assign hit_xds  = at_start && xds_enable && (line_num == XDS_V) && field;
  assign take     = {hit_xds, hit_cc};
  assign start    = hit_cc || hit_xds;
  assign payload  = hit_xds ? pairs[1] : pairs[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cc_pair_store #(.CH_ID(g)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .take      (take[g]),
      .send_pair (pairs[g]),
      .fresh     (fresh_v[g])
    );
  end

  cc_wave_ser #(
    .BIT_TICKS  (BIT_TICKS),
    .RUNIN_BITS (RUNIN_BITS),
    .DATA_BITS  (16)
  ) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (pix_tick),
    .start   (start),
    .payload (payload),
    .active  (cc_active),
    .level   (cc_level)
  );

  // R4
  slot_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_active) |-> (($past(line_num) == CC_V && !$past(field)) ||
                          ($past(line_num) == XDS_V && $past(field))));
  // R4
  slot_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_active) |-> ($past(pix_tick) && $past(pix_pos) == START_V));
  // R9
  one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
endmodule

// File: tb/cc_line_inserter_bench.sv
module cc_line_inserter_bench;
  localparam int S    = 130;
  localparam int BT   = 27;
  localparam int NB   = 26;
  localparam int LLEN = 858;

  typedef struct packed {
    logic [1:0]  wmode;   // 0 none, 1 pair, 2 first byte only
    logic        ch;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [9:0]  ln;
    logic        fld;
    logic        ce;
    logic        xe;
    logic        act;
    logic [15:0] exp_d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 8'h91, 8'h23, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'h2391}, // R2 R5
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'h8080}, // R3
    '{2'd1, 1'b1, 8'h15, 8'hA7, 10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'hA715}, // R9 R4
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8080}, // R3
    '{2'd1, 1'b0, 8'h4C, 8'hE5, 10'd21,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0000}, // R4 wrong field
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'hE54C}, // R4 kept
    '{2'd2, 1'b0, 8'h5A, 8'h00, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'h8080}, // R2 first only
    '{2'd1, 1'b1, 8'h33, 8'hC4, 10'd284, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000}, // R4 disabled
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'h8080}, // R9
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'hC433}, // R9
    '{2'd1, 1'b0, 8'hFF, 8'h7F, 10'd21,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0000}, // R4 cc off
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd20,  1'b0, 1'b1, 1'b1, 1'b0, 16'h0000}, // R4 wrong line
    '{2'd0, 1'b0, 8'h00, 8'h00, 10'd21,  1'b0, 1'b1, 1'b1, 1'b1, 16'h7FFF}, // R8
    '{2'd1, 1'b1, 8'h00, 8'h01, 10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0100}  // R8
  };

  logic       clk = 1'b0;
  logic       rst_n, pix_tick, wr_en, cc_enable, xds_enable, field;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [9:0] line_num;
  logic [10:0] pix_pos;
  logic       cc_active, cc_level;

  int errs = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cc_line_inserter u_cc_line_inserter (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cc_enable(cc_enable),
    .xds_enable(xds_enable), .line_num(line_num), .field(field),
    .pix_pos(pix_pos), .cc_active(cc_active), .cc_level(cc_level)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input logic [9:0] ln, input logic fl, input logic ce,
                          input logic xe, input logic exp_act, input logic [15:0] exp_d,
                          input logic mid, input logic mch, input logic [7:0] m0,
                          input logic [7:0] m1);
    logic [25:0] fr;
    logic [6:0]  rlow;
    int          act_err;
    fr = '0; rlow = '0; act_err = 0;
    @(negedge clk);
    line_num = ln; field = fl; cc_enable = ce; xde_set(xe);
    for (int p = 0; p < LLEN; p++) begin
      int o;
      pix_pos = 11'(p); pix_tick = 1'b1;
      if (mid && p == S + 100) begin
        wr_en = 1'b1; wr_addr = {mch, 1'b0}; wr_data = m0;
      end else if (mid && p == S + 101) begin
        wr_en = 1'b0;
      end
      @(negedge clk);
      o = p - S;
      if (exp_act && o >= 0 && o < NB * BT) begin
        if (cc_active !== 1'b1) act_err++;
        if (o % BT == 6) fr[o / BT] = cc_level;
        if (o / BT < 7 && o % BT == 20) rlow[o / BT] = cc_level;
      end else begin
        if (cc_active !== 1'b0 || cc_level !== 1'b0) act_err++;
      end
      pix_tick = 1'b0;
      if (mid && p == S + 100) begin
        wr_addr = {mch, 1'b1}; wr_data = m1;
      end
      @(negedge clk);
    end
    // R6: active window and idle level
    chk("R6 active window mismatches", 32'(act_err), 32'd0);
    if (exp_act) begin
      // R5 framing: run-in highs, start bits 0,0,1
      chk("R5 run-in and start bits", {22'd0, fr[9:0]}, {22'd0, 3'b100, 7'h7F});
      chk("R5 run-in low halves", {25'd0, rlow}, 32'd0);
      chk("R2 R3 R7 R8 R9 payload bits", {16'd0, fr[25:10]}, {16'd0, exp_d});
    end
  endtask

  task automatic xde_set(input logic xe);
    xds_enable = xe;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pix_tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cc_enable = 1'b0; xds_enable = 1'b0; field = 1'b0; line_num = '0; pix_pos = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of outputs
    chk("R1 cc_active after reset", {31'd0, cc_active}, 32'd0);
    chk("R1 cc_level after reset", {31'd0, cc_level}, 32'd0);
    // R1: first bursts carry nulls
    run_line(10'd21, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8080, 1'b0, 1'b0, 8'h00, 8'h00);
    run_line(10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8080, 1'b0, 1'b0, 8'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wmode != 2'd0) wr_byte({VECS[i].ch, 1'b0}, VECS[i].b0);
      if (VECS[i].wmode == 2'd1) wr_byte({VECS[i].ch, 1'b1}, VECS[i].b1);
      run_line(VECS[i].ln, VECS[i].fld, VECS[i].ce, VECS[i].xe, VECS[i].act,
               VECS[i].exp_d, 1'b0, 1'b0, 8'h00, 8'h00);
    end

    // R7: pair written during a burst goes out on the next burst
    wr_byte(2'd0, 8'h11);
    wr_byte(2'd1, 8'h22);
    run_line(10'd21, 1'b0, 1'b1, 1'b1, 1'b1, 16'h2211, 1'b1, 1'b0, 8'h33, 8'h44);
    run_line(10'd21, 1'b0, 1'b1, 1'b1, 1'b1, 16'h4433, 1'b0, 1'b0, 8'h00, 8'h00);
    run_line(10'd21, 1'b0, 1'b1, 1'b1, 1'b1, 16'h8080, 1'b0, 1'b0, 8'h00, 8'h00);
    // R9: write to caption channel during an extended-data burst
    run_line(10'd284, 1'b1, 1'b1, 1'b1, 1'b1, 16'h8080, 1'b1, 1'b0, 8'h5E, 8'h6B);
    run_line(10'd21, 1'b0, 1'b1, 1'b1, 1'b1, 16'h6B5E, 1'b0, 1'b0, 8'h00, 8'h00);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule